// File: doc/BRIEF.md
# TDM Audio Slot Receiver

The receiver turns one serial audio data line into as many as eight parallel channel words. It is clocked by the external bit clock and watches a frame clock. Each received channel has its own enable and its own slot index, so channels may be placed in any order within the frame. A shared slot length, word length, frame length in bits and a format select control where each slot lies. In the DSP format, slots follow one another from the start of the frame. In the I2S and left-justified formats, even slots sit in the first half of the frame and odd slots in the second half.

Each captured word is left-aligned into a 24-bit output. When a frame ends, every enabled channel output takes its new value on the same edge, and a one-cycle valid strobe goes high. If a frame edge comes early, the bit count restarts and a sticky error flag is set. The control core is a two-state machine. IDLE waits for a frame start. RUN counts bit positions. IDLE goes to RUN on a frame start. RUN goes back to IDLE after the last bit position. RUN restarts itself on an early frame edge, and this sets the error flag.

Top module: `tdm_slot_rx`

## Requirements
- R1: After reset every channel output is zero, and `frame_valid` and `frame_err` are low.
- R2: DSP format (`fmt`=0, 3 behaves the same): a frame starts at a rising `fsync` sample. Frame bit 0 is the `sdata` sample on the next bit clock. Slot s begins at bit s*`slot_len`.
- R3: I2S format (`fmt`=1): a frame starts at a falling `fsync` sample, and bit 0 is the next `sdata` sample. An even slot s begins at bit (s/2)*`slot_len`. An odd slot begins at `frame_bits`/2 + (s/2)*`slot_len`.
- R4: Left-justified format (`fmt`=2): a frame starts at a rising `fsync` sample, and bit 0 is the `sdata` sample taken on that same clock. Slot placement is the same as in R3.
- R5: From each slot, the first `word_len` bits (1 to 24, no more than `slot_len`) are captured MSB first. The first bit lands in bit 23 of the channel word. The unused low bits read zero, and the remaining slot bits are ignored.
- R6: `frame_valid` pulses for one cycle, one clock after the frame's last bit position (`frame_bits`-1, with `frame_bits` at least 2). All enabled channel outputs change on that same edge.
- R7: A channel whose `ch_en` bit is low keeps its previous output value.
- R8: A frame start before `frame_bits` positions have elapsed restarts the count at bit 0 and sets `frame_err`, which stays high until reset. The interrupted frame produces no output update and no `frame_valid` pulse.
- R9: Each channel c takes its slot index from `ch_slot[3c+2:3c]`, independent of the others. Channel c's word appears on `ch_data[24c+23:24c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame clock |
| sdata | input | 1 | Serial audio data |
| fmt | input | 2 | Format: 0 DSP, 1 I2S, 2 left-justified |
| slot_len | input | 6 | Bit clocks per slot |
| word_len | input | 5 | Valid bits per slot, 1 to 24 |
| frame_bits | input | 10 | Bit clocks per frame |
| ch_en | input | 8 | Per-channel enable |
| ch_slot | input | 24 | Per-channel slot index, 3 bits each |
| ch_data | output | 192 | Per-channel left-aligned words, 24 bits each |
| frame_valid | output | 1 | One-cycle strobe when a frame completes |
| frame_err | output | 1 | Sticky early-frame-edge flag |

## Verification
A bit-position counter that is off by one shifts every captured word by one bit. This is visible on `ch_data` at the very first `frame_valid`, one frame after the error. A state machine stuck in RUN or IDLE causes missing or extra `frame_valid` pulses, or a false `frame_err`, within a frame or two. A capture register that is not cleared at a frame start leaves stray ones in the low bits below `word_len`. The bench compares every output on every clock against a model built from the frame bits it sends, so any of these faults is caught at the first update that follows it.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    typedef enum logic [1:0] {
        FMT_DSP = 2'd0,
        FMT_I2S = 2'd1,
        FMT_LJ  = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;
endpackage

// File: rtl/tdm_rx_front.sv
// Frame-edge detection and data alignment: emits a frame-start flag that is
// coincident with the bit-0 data sample for every format.
module tdm_rx_front
    import tdm_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  fmt_e fmt,
    input  logic fsync,
    input  logic sdata,
    output logic start_o,
    output logic bit_o
);
    logic fs_q;
    logic sd_q;
    logic ev_q;
    logic edge_now;

    always_comb begin
        case (fmt)
            FMT_I2S: edge_now = fs_q & ~fsync;
            default: edge_now = ~fs_q & fsync;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= 1'b0;
            sd_q <= 1'b0;
            ev_q <= 1'b0;
        end else begin
            fs_q <= fsync;
            sd_q <= sdata;
            ev_q <= edge_now;
        end
    end

    // Left-justified data is already valid at the edge sample; others lag one bit.
    assign start_o = ev_q;
    assign bit_o   = (fmt == FMT_LJ) ? sd_q : sdata;
endmodule

// File: rtl/tdm_rx_seq.sv
// Frame sequencer: bit-position counter, frame completion, framing error.
module tdm_rx_seq
    import tdm_rx_pkg::*;
#(
    parameter int POSW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [POSW-1:0] frame_bits,
    output logic [POSW-1:0] pos_o,
    output logic            active_o,
    output logic            last_o,
    output logic            valid_o,
    output logic            err_o
);
    seq_st_e         state_q, state_d;
    logic [POSW-1:0] pos_q;
    logic [POSW-1:0] cur_pos;
    logic            active;
    logic            last;
    logic            early;
    logic            valid_q;
    logic            err_q;

    assign cur_pos = start_i ? '0 : pos_q;
    assign active  = start_i || (state_q == ST_RUN);
    assign last    = active && (cur_pos == frame_bits - POSW'(1));
    assign early   = start_i && (state_q == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i && !last) state_d = ST_RUN;
            ST_RUN:  if (last)             state_d = ST_IDLE;
        endcase
    end

    // outputs and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (active) pos_q <= cur_pos + POSW'(1);
            valid_q <= last;
            if (early) err_q <= 1'b1;
        end
    end

    assign pos_o    = cur_pos;
    assign active_o = active;
    assign last_o   = last;
    assign valid_o  = valid_q;
    assign err_o    = err_q;

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    p_err_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(start_i));
endmodule

// File: rtl/tdm_rx_lane.sv
// One receive channel: slot placement, bit capture, frame-end commit.
module tdm_rx_lane
    import tdm_rx_pkg::*;
#(
    parameter int SW    = 24,
    parameter int POSW  = 10,
    parameter int SLW   = 6,
    parameter int SLOTW = 3,
    parameter int WLW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_e             fmt,
    input  logic [SLOTW-1:0] slot,
    input  logic [SLW-1:0]   slot_len,
    input  logic [WLW-1:0]   word_len,
    input  logic [POSW-1:0]  half,
    input  logic [POSW-1:0]  pos,
    input  logic             active,
    input  logic             start,
    input  logic             last,
    input  logic             bit_i,
    input  logic             en,
    output logic [SW-1:0]    data_o
);
    logic            split;
    logic [SLOTW-1:0] idx;
    logic [POSW-1:0] st;
    logic [POSW-1:0] off;
    logic            hit;
    logic [SW-1:0]   sh_q, sh_d;
    logic [SW-1:0]   data_q;

    assign split = (fmt == FMT_I2S) || (fmt == FMT_LJ);
    assign idx   = split ? (slot >> 1) : slot;
    assign st    = ((split && slot[0]) ? half : '0) + POSW'(idx) * POSW'(slot_len);
    assign off   = pos - st;
    assign hit   = active && en && (pos >= st) && (off < POSW'(word_len));

    always_comb begin
        sh_d = start ? '0 : sh_q;
        for (int i = 0; i < SW; i++) begin
            if (hit && off == POSW'(i)) sh_d[SW-1-i] = bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            data_q <= '0;
        end else begin
            sh_q <= sh_d;
            if (last && en) data_q <= sh_d;
        end
    end

    assign data_o = data_q;

    p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(data_o));
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_rx_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int SW   = 24,
    parameter int POSW = 10,
    parameter int SLW  = 6,
    localparam int SLOTW = $clog2(NCH),
    localparam int WLW   = $clog2(SW + 1)
) (
    input  logic                 bclk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic                 sdata,
    input  logic [1:0]           fmt,
    input  logic [SLW-1:0]       slot_len,
    input  logic [WLW-1:0]       word_len,
    input  logic [POSW-1:0]      frame_bits,
    input  logic [NCH-1:0]       ch_en,
    input  logic [NCH*SLOTW-1:0] ch_slot,
    output logic [NCH*SW-1:0]    ch_data,
    output logic                 frame_valid,
    output logic                 frame_err
);
    fmt_e            fmt_sel;
    logic            start;
    logic            bit_cur;
    logic [POSW-1:0] pos;
    logic            active;
    logic            last;
    logic [POSW-1:0] half;

    assign fmt_sel = fmt_e'(fmt);
    assign half    = frame_bits >> 1;

    tdm_rx_front u_front (
        .clk     (bclk),
        .rst_n   (rst_n),
        .fmt     (fmt_sel),
        .fsync   (fsync),
        .sdata   (sdata),
        .start_o (start),
        .bit_o   (bit_cur)
    );

    tdm_rx_seq #(.POSW(POSW)) u_seq (
        .clk        (bclk),
        .rst_n      (rst_n),
        .start_i    (start),
        .frame_bits (frame_bits),
        .pos_o      (pos),
        .active_o   (active),
        .last_o     (last),
        .valid_o    (frame_valid),
        .err_o      (frame_err)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        tdm_rx_lane #(
            .SW(SW), .POSW(POSW), .SLW(SLW), .SLOTW(SLOTW), .WLW(WLW)
        ) u_lane (
            .clk      (bclk),
            .rst_n    (rst_n),
            .fmt      (fmt_sel),
            .slot     (ch_slot[c*SLOTW +: SLOTW]),
            .slot_len (slot_len),
            .word_len (word_len),
            .half     (half),
            .pos      (pos),
            .active   (active),
            .start    (start),
            .last     (last),
            .bit_i    (bit_cur),
            .en       (ch_en[c]),
            .data_o   (ch_data[c*SW +: SW])
        );
    end
endmodule

// File: tb/sim_tdm_slot_rx.sv
module sim_tdm_slot_rx;
    logic         bclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fsync = 1'b0;
    logic         sdata = 1'b0;
    logic [1:0]   fmt = 2'd0;
    logic [5:0]   slot_len = 6'd8;
    logic [4:0]   word_len = 5'd8;
    logic [9:0]   frame_bits = 10'd64;
    logic [7:0]   ch_en = 8'h00;
    logic [23:0]  ch_slot = '0;
    wire  [191:0] ch_data;
    wire          frame_valid;
    wire          frame_err;

    tdm_slot_rx u0 (
        .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
        .fmt(fmt), .slot_len(slot_len), .word_len(word_len),
        .frame_bits(frame_bits), .ch_en(ch_en), .ch_slot(ch_slot),
        .ch_data(ch_data), .frame_valid(frame_valid), .frame_err(frame_err)
    );

    always #4 bclk = ~bclk;   // 125 MHz

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [191:0] exp_data = '0;
    bit           exp_err = 1'b0;
    bit           s_fs[$];
    bit           s_sd[$];
    int           ev_idx[$];
    logic [191:0] ev_word[$];
    int           err_idx = -1;
    int           slot_of[8];

    task automatic check(bit ok, string tag, logic [193:0] act, logic [193:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual {valid,err,data}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_slots(int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
        slot_of[0] = a0; slot_of[1] = a1; slot_of[2] = a2; slot_of[3] = a3;
        slot_of[4] = a4; slot_of[5] = a5; slot_of[6] = a6; slot_of[7] = a7;
        for (int c = 0; c < 8; c++) ch_slot[c*3 +: 3] = slot_of[c][2:0];
    endtask

    // Build the stimulus stream and the expected events for one phase.
    task automatic build(int f, int sl, int wl, int nfr, int cut_frame, int cut_len);
        int pre = 3;
        int cum = 0;
        int d = (fmt == 2'd2) ? 0 : 1;
        bit il = (fmt == 2'd1);
        bit bq[$];
        s_fs.delete(); s_sd.delete(); ev_idx.delete(); ev_word.delete();
        err_idx = -1;
        for (int i = 0; i < pre; i++) s_fs.push_back(il);
        for (int fr = 0; fr < nfr; fr++) begin
            int len = (fr == cut_frame) ? cut_len : f;
            bit fb[1024];
            logic [191:0] w = '0;
            if (cut_frame >= 0 && fr == cut_frame + 1) err_idx = pre + cum + 1;
            for (int i = 0; i < len; i++) begin
                bit fsv;
                if (fmt == 2'd1)      fsv = (i >= f/2);
                else if (fmt == 2'd2) fsv = (i < f/2);
                else                  fsv = (i == 0);
                s_fs.push_back(fsv);
                fb[i] = 1'($urandom);
                bq.push_back(fb[i]);
            end
            if (len == f) begin
                for (int c = 0; c < 8; c++) begin
                    int s = slot_of[c];
                    int st = (fmt == 2'd1 || fmt == 2'd2)
                           ? ((s % 2) * (f/2) + (s/2) * sl) : s * sl;
                    for (int b = 0; b < wl; b++) w[c*24 + 23 - b] = fb[st + b];
                end
                ev_idx.push_back(pre + cum + len);
                ev_word.push_back(w);
            end
            cum += len;
        end
        for (int i = 0; i < 4; i++) s_fs.push_back(il);
        for (int i = 0; i < pre + d; i++) s_sd.push_back(1'b0);
        foreach (bq[i]) s_sd.push_back(bq[i]);
        while (s_sd.size() < s_fs.size()) s_sd.push_back(1'b0);
    endtask

    // Model update and comparison for the posedge that consumed element j.
    task automatic cmp(int j, string tag);
        bit ev = (ev_idx.size() > 0 && ev_idx[0] == j);
        if (ev) begin
            logic [191:0] raw = ev_word.pop_front();
            void'(ev_idx.pop_front());
            for (int c = 0; c < 8; c++)
                if (ch_en[c]) exp_data[c*24 +: 24] = raw[c*24 +: 24];
        end
        if (j == err_idx) exp_err = 1'b1;
        check(frame_valid == ev && frame_err == exp_err && ch_data == exp_data, tag,
              {frame_valid, frame_err, ch_data}, {ev, exp_err, exp_data});
    endtask

    task automatic play(string tag);
        for (int i = 0; i < s_fs.size(); i++) begin
            @(negedge bclk);
            if (i > 0) cmp(i - 1, tag);
            fsync = s_fs[i];
            sdata = s_sd[i];
        end
        @(negedge bclk);
        cmp(s_fs.size() - 1, tag);
    endtask

    task automatic reset_check(string tag);
        rst_n = 1'b0;
        repeat (2) @(negedge bclk);
        exp_data = '0; exp_err = 1'b0;
        check(ch_data == '0 && !frame_valid && !frame_err, tag,
              {frame_valid, frame_err, ch_data}, '0);
        rst_n = 1'b1;
        @(negedge bclk);
        check(ch_data == '0 && !frame_valid && !frame_err, tag,
              {frame_valid, frame_err, ch_data}, '0);
    endtask

    initial begin
        reset_check("R1 reset state");

        // DSP, all eight channels, scrambled slot order
        fmt = 2'd0; slot_len = 6'd8; word_len = 5'd8; frame_bits = 10'd64; ch_en = 8'hFF;
        set_slots(5, 2, 7, 0, 3, 6, 1, 4);
        build(64, 8, 8, 3, -1, 0);
        play("R2 R9 R6 DSP");

        // I2S, half-frame split, short words, upper channels disabled
        fmt = 2'd1; slot_len = 6'd16; word_len = 5'd12; frame_bits = 10'd64; ch_en = 8'h0F;
        set_slots(0, 1, 2, 3, 0, 0, 0, 0);
        build(64, 16, 12, 2, -1, 0);
        play("R3 R5 R7 I2S");

        // Left-justified, full 24-bit words, reversed slots
        fmt = 2'd2; slot_len = 6'd24; word_len = 5'd24; frame_bits = 10'd128; ch_en = 8'h0F;
        set_slots(3, 2, 1, 0, 0, 0, 0, 0);
        build(128, 24, 24, 2, -1, 0);
        play("R4 R5 R7 LJ");

        // Early frame edge in DSP
        fmt = 2'd0; slot_len = 6'd8; word_len = 5'd6; frame_bits = 10'd32; ch_en = 8'h0F;
        set_slots(0, 1, 2, 3, 4, 5, 6, 7);
        build(32, 8, 6, 3, 1, 20);
        play("R8 early edge");

        reset_check("R1 reset clears error");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6 watchdog: actual hung expected finished run");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule